// File: doc/BRIEF.md
# Vectored Thirty-Two Source Interrupt Controller

This block gathers thirty-two interrupt request lines into two processor request outputs, one critical and one non-critical. Each line is first conditioned: a per-source polarity bit decides whether a high or a low level counts as active, and a per-source trigger bit decides whether the source is level-sensitive or latches on the edge where it becomes active. Conditioned requests land in a status word. Software can clear it bit by bit or force bits on, and an enable word gates it into a masked status word. A per-source routing bit sends every masked request either to the critical output or to the non-critical one.

The block also produces a ready-made handler address for the most urgent masked request. That address is a software-chosen base plus 512 bytes times the winning source's position in priority order. A configuration bit selects which end of the source range is most urgent. Sources are numbered from the most significant end of the word: source N lives in word bit 31-N. The raw input bus uses the same bit layout, so `irq_in[b]` feeds source 31-b. Software reaches the block through a simple register port. A write takes effect at the clock edge where `reg_we` is high, and read data is a combinational function of `reg_addr`.

Top module: `vic_top`

## Requirements
- R1: Synchronous reset clears the status, enable, critical-select, polarity, trigger and vector-configuration words to zero, so every source starts disabled, active-low, level-sensitive and non-critical.
- R2: A source is active when its input bit equals its polarity bit (polarity 0 = active-low, 1 = active-high). Source N uses bit 31-N of every word and of `irq_in`.
- R3: For a level-sensitive source (trigger bit 0), the status bit equals the source's active state sampled at the previous clock edge. A clear written while the source is still active has no lasting effect.
- R4: For an edge-sensitive source (trigger bit 1), the status bit is set at the clock edge after the source goes from inactive to active. It then stays set until software clears it. A source that is held active does not set the bit again.
- R5: A write to offset 0x00 clears each status bit whose data bit is 1, and leaves bits written with 0 unchanged. Reading 0x00 returns the status word.
- R6: A write to offset 0x04 sets each status bit whose data bit is 1, with priority over a clear. Reading 0x04 returns zero.
- R7: Offset 0x18 reads the masked status, which is status AND the enable word at offset 0x08. When the masked status is zero, both request outputs are low.
- R8: `irq_crit` is the OR of the masked bits whose critical-select bit (offset 0x0C) is 1. `irq_norm` is the OR of the masked bits whose critical-select bit is 0.
- R9: With bit 0 of the vector-configuration word (offset 0x20) set, source 0 is most urgent. Offset 0x1C then reads (cfg AND NOT 3) + N*512, where N is the lowest-numbered masked source.
- R10: With that bit clear, source 31 is most urgent. Offset 0x1C then reads (cfg AND NOT 3) + (31-N)*512, where N is the highest-numbered masked source.
- R11: Offset 0x1C reads zero when no masked source is pending. The address sum wraps modulo 2^32, and bits 1:0 of the configuration word never reach the sum.
- R12: Writes to offsets 0x18, 0x1C, to offsets at or beyond 0x24, or to addresses with nonzero bits 1:0 change no register. Reads of those addresses return zero, and offset 0x20 reads back all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_in | input | 32 | Raw interrupt inputs, bit b feeds source 31-b |
| irq_crit | output | 1 | Critical interrupt request |
| irq_norm | output | 1 | Non-critical interrupt request |

## Verification
The bench attacks the priority direction with two masked sources at opposite ends of the range and flips the order bit. A design that decodes the order bit backwards, or maps sources LSB-first, returns a vector off by many 512-byte steps. The bench holds an edge source active across a clear to catch a design that re-latches on level. It writes clears to level sources that are still asserted, and writes zero to the clear offset, to expose a clear that sticks or a clear written as a plain store. It drives a base near the top of the address space to check the wrap and the dropped low bits. It writes to read-only, unmapped and misaligned addresses, where a loose decoder would corrupt the enable or configuration words.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int unsigned SRC_N   = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned STEP_SH = 9;
    localparam int unsigned IDX_W   = $clog2(SRC_N);

    typedef logic [SRC_N-1:0]  src_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    // word index = byte address / 4
    typedef enum logic [3:0] {
        RI_STAT   = 4'd0,
        RI_SET    = 4'd1,
        RI_EN     = 4'd2,
        RI_CRIT   = 4'd3,
        RI_POL    = 4'd4,
        RI_TRIG   = 4'd5,
        RI_MASKED = 4'd6,
        RI_VEC    = 4'd7,
        RI_VCFG   = 4'd8
    } reg_idx_e;

    typedef struct packed {
        logic clr;
        logic set;
        logic en;
        logic crit;
        logic pol;
        logic trig;
        logic vcfg;
    } wr_sel_t;

    typedef struct packed {
        src_vec_t en;
        src_vec_t crit;
        src_vec_t pol;
        src_vec_t trig;
        word_t    vcfg;
    } cfg_t;

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] <= (ADDR_W-2)'(RI_VCFG));
    endfunction

    function automatic wr_sel_t decode_wr(input logic we, input logic [ADDR_W-1:0] a);
        wr_sel_t s;
        logic    ok;
        ok     = we && addr_ok(a);
        s.clr  = ok && (a[5:2] == RI_STAT);
        s.set  = ok && (a[5:2] == RI_SET);
        s.en   = ok && (a[5:2] == RI_EN);
        s.crit = ok && (a[5:2] == RI_CRIT);
        s.pol  = ok && (a[5:2] == RI_POL);
        s.trig = ok && (a[5:2] == RI_TRIG);
        s.vcfg = ok && (a[5:2] == RI_VCFG);
        return s;
    endfunction

endpackage

// File: rtl/vic_cond.sv
module vic_cond
    import vic_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] set_mask,
    output logic [N-1:0] status
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic act;
        logic prev_q;
        logic st_q;
        logic rise;

        assign act  = ~(raw[g] ^ pol[g]);
        assign rise = act & ~prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                st_q   <= 1'b0;
            end else begin
                prev_q <= act;
                if (trig[g]) begin
                    st_q <= (st_q & ~clr_mask[g]) | rise | set_mask[g];
                end else begin
                    st_q <= act | set_mask[g];
                end
            end
        end

        assign status[g] = st_q;
    end

endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  word_t             reg_wdata,
    input  src_vec_t          status,
    input  src_vec_t          masked,
    input  word_t             vec,
    output cfg_t              cfg,
    output src_vec_t          clr_mask,
    output src_vec_t          set_mask,
    output word_t             reg_rdata
);

    wr_sel_t sel;
    cfg_t    cfg_q;

    assign sel = decode_wr(reg_we, reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (sel.en)   cfg_q.en   <= reg_wdata[SRC_N-1:0];
            if (sel.crit) cfg_q.crit <= reg_wdata[SRC_N-1:0];
            if (sel.pol)  cfg_q.pol  <= reg_wdata[SRC_N-1:0];
            if (sel.trig) cfg_q.trig <= reg_wdata[SRC_N-1:0];
            if (sel.vcfg) cfg_q.vcfg <= reg_wdata;
        end
    end

    assign cfg      = cfg_q;
    assign clr_mask = sel.clr ? reg_wdata[SRC_N-1:0] : '0;
    assign set_mask = sel.set ? reg_wdata[SRC_N-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        if (addr_ok(reg_addr)) begin
            case (reg_idx_e'(reg_addr[5:2]))
                RI_STAT:   reg_rdata = DATA_W'(status);
                RI_EN:     reg_rdata = DATA_W'(cfg_q.en);
                RI_CRIT:   reg_rdata = DATA_W'(cfg_q.crit);
                RI_POL:    reg_rdata = DATA_W'(cfg_q.pol);
                RI_TRIG:   reg_rdata = DATA_W'(cfg_q.trig);
                RI_MASKED: reg_rdata = DATA_W'(masked);
                RI_VEC:    reg_rdata = vec;
                RI_VCFG:   reg_rdata = cfg_q.vcfg;
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
#(
    parameter int unsigned N  = SRC_N,
    parameter int unsigned SH = STEP_SH
) (
    input  logic [N-1:0]   masked,
    input  logic           src0_first,
    input  logic [DATA_W-1:2] base,
    output word_t          vec
);

    localparam int unsigned IW = $clog2(N);

    logic [IW-1:0] lo_bit;
    logic [IW-1:0] hi_bit;
    logic [IW-1:0] ofs;

    always_comb begin
        lo_bit = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (masked[i]) lo_bit = IW'(i);
        end
        hi_bit = '0;
        for (int i = 0; i < N; i++) begin
            if (masked[i]) hi_bit = IW'(i);
        end
    end

    // source index N = (N_SRC-1) - bit; offset is that index or its mirror
    always_comb begin
        if (src0_first) ofs = IW'(N - 1) - hi_bit;
        else            ofs = lo_bit;
    end

    assign vec = (masked == '0) ? '0
               : ({base, 2'b00} + (DATA_W'(ofs) << SH));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] irq_in,
    output logic        irq_crit,
    output logic        irq_norm
);

    cfg_t     cfg;
    src_vec_t st;
    src_vec_t masked;
    src_vec_t clr_mask;
    src_vec_t set_mask;
    src_vec_t en_v;
    src_vec_t crit_v;
    src_vec_t trig_v;
    word_t    vcfg_v;
    word_t    vec;

    assign en_v   = cfg.en;
    assign crit_v = cfg.crit;
    assign trig_v = cfg.trig;
    assign vcfg_v = cfg.vcfg;

    vic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (st),
        .masked    (masked),
        .vec       (vec),
        .cfg       (cfg),
        .clr_mask  (clr_mask),
        .set_mask  (set_mask),
        .reg_rdata (reg_rdata)
    );

    vic_cond #(.N(SRC_N)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .raw      (irq_in),
        .pol      (cfg.pol),
        .trig     (trig_v),
        .clr_mask (clr_mask),
        .set_mask (set_mask),
        .status   (st)
    );

    assign masked = st & en_v;

    vic_prio #(.N(SRC_N), .SH(STEP_SH)) u_prio (
        .masked     (masked),
        .src0_first (vcfg_v[0]),
        .base       (vcfg_v[DATA_W-1:2]),
        .vec        (vec)
    );

    assign irq_crit = |(masked & crit_v);
    assign irq_norm = |(masked & ~crit_v);

endmodule

// File: rtl/vic_chk.sv
module vic_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] st,
    input logic [31:0] en,
    input logic [31:0] trig,
    input logic [31:0] vcfg,
    input logic [31:0] reg_rdata,
    input logic        irq_crit,
    input logic        irq_norm
);

    logic clr_wr;
    logic set_wr;
    logic rd_vec;

    assign clr_wr = reg_we && (reg_addr == 6'h00);
    assign set_wr = reg_we && (reg_addr == 6'h04);
    assign rd_vec = (reg_addr == 6'h1C);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st == '0 && en == '0 && trig == '0 && vcfg == '0));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> (($past(st & trig) & ~st) == '0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((st & $past(reg_wdata)) == $past(reg_wdata)));

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((st & en) == '0) |-> (!irq_crit && !irq_norm));

    // R11
    idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (((st & en) == '0) && rd_vec) |-> (reg_rdata == '0));

endmodule

bind vic_top vic_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .st        (st),
    .en        (en_v),
    .trig      (trig_v),
    .vcfg      (vcfg_v),
    .reg_rdata (reg_rdata),
    .irq_crit  (irq_crit),
    .irq_norm  (irq_norm)
);

// File: tb/vic_top_test.sv
module vic_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_in = 32'hFFFF_FFFF;
    logic        irq_crit;
    logic        irq_norm;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // scoreboard queues: kind 0 = register read, 1 = request outputs
    bit          q_kind[$];
    logic [5:0]  q_addr[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    vic_top uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .irq_crit  (irq_crit),
        .irq_norm  (irq_norm)
    );

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_we   = 1'b0;
        reg_addr = a;
        #1;
        q_kind.push_back(1'b0);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        @(negedge clk);
        #1;
        q_kind.push_back(1'b1);
        q_addr.push_back('0);
        q_exp.push_back({30'b0, e});
        q_tag.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            bit          k;
            logic [5:0]  a;
            logic [31:0] e;
            logic [31:0] got;
            string       t;
            wait (q_exp.size() != 0);
            k = q_kind.pop_front();
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            got = k ? {30'b0, irq_crit, irq_norm} : reg_rdata;
            total++;
            if (got !== e) begin
                bad++;
                if (k) $display("FAIL %s: irq {crit,norm} got %b expected %b", t, got[1:0], e[1:0]);
                else   $display("FAIL %s: addr 0x%02h got 0x%08h expected 0x%08h", t, a, got, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a <= 8; a++) chk_rd(6'(a * 4), 32'h0, "R1");
        chk_irq(2'b00, "R1");

        // R2/R3 level, active-low source 26 (bit 5)
        drive(32'hFFFF_FFDF);
        chk_rd(6'h00, 32'h0000_0020, "R2");
        chk_irq(2'b00, "R7");
        wr(6'h08, 32'h0000_0020);
        chk_rd(6'h18, 32'h0000_0020, "R7");
        chk_irq(2'b01, "R8");
        wr(6'h0C, 32'h0000_0020);
        chk_irq(2'b10, "R8");
        wr(6'h00, 32'h0000_0020);
        chk_rd(6'h00, 32'h0000_0020, "R3");
        drive(32'hFFFF_FFFF);
        chk_rd(6'h00, 32'h0, "R3");
        chk_irq(2'b00, "R7");

        // R2 polarity
        wr(6'h10, 32'h0000_0004);
        chk_rd(6'h00, 32'h0000_0004, "R2");
        wr(6'h10, 32'hFFFF_FFFF);
        chk_rd(6'h00, 32'hFFFF_FFFF, "R2");
        drive(32'h0);
        chk_rd(6'h00, 32'h0, "R2");

        // R4/R5 edge on source 23 (bit 8)
        wr(6'h14, 32'h0000_0100);
        drive(32'h0000_0100);
        drive(32'h0);
        chk_rd(6'h00, 32'h0000_0100, "R4");
        repeat (4) @(negedge clk);
        chk_rd(6'h00, 32'h0000_0100, "R4");
        wr(6'h00, 32'h0);
        chk_rd(6'h00, 32'h0000_0100, "R5");
        wr(6'h00, 32'h0000_0100);
        chk_rd(6'h00, 32'h0, "R5");
        drive(32'h0000_0100);
        wr(6'h00, 32'h0000_0100);
        chk_rd(6'h00, 32'h0, "R4");
        drive(32'h0);

        // R6 set
        wr(6'h04, 32'h0000_0100);
        chk_rd(6'h00, 32'h0000_0100, "R6");
        chk_rd(6'h04, 32'h0, "R6");
        wr(6'h00, 32'h0000_0100);

        // R9/R10/R11 vector
        wr(6'h14, 32'hFFFF_FFFF);
        wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h0C, 32'h0);
        wr(6'h20, 32'h0001_2347);
        chk_rd(6'h1C, 32'h0, "R11");
        chk_rd(6'h20, 32'h0001_2347, "R12");
        wr(6'h04, 32'h0000_0011);
        chk_rd(6'h1C, 32'h0001_5944, "R9");
        wr(6'h20, 32'h0001_2346);
        chk_rd(6'h1C, 32'h0001_2344, "R10");
        wr(6'h04, 32'h8000_0000);
        chk_rd(6'h1C, 32'h0001_2344, "R10");
        wr(6'h00, 32'h0000_0001);
        chk_rd(6'h1C, 32'h0001_2B44, "R10");
        wr(6'h20, 32'h0001_2347);
        chk_rd(6'h1C, 32'h0001_2344, "R9");
        wr(6'h08, 32'h7FFF_FFFF);
        chk_rd(6'h1C, 32'h0001_5944, "R9");
        chk_rd(6'h18, 32'h0000_0010, "R7");
        chk_irq(2'b01, "R8");
        wr(6'h20, 32'hFFFF_FFFE);
        chk_rd(6'h1C, 32'h0000_07FC, "R11");

        // R12 ignored writes
        wr(6'h1C, 32'h0000_DEAD);
        chk_rd(6'h1C, 32'h0000_07FC, "R12");
        chk_rd(6'h20, 32'hFFFF_FFFE, "R12");
        wr(6'h24, 32'hFFFF_FFFF);
        chk_rd(6'h24, 32'h0, "R12");
        wr(6'h09, 32'h0);
        chk_rd(6'h08, 32'h7FFF_FFFF, "R12");
        chk_rd(6'h09, 32'h0, "R12");
        wr(6'h18, 32'h0);
        chk_rd(6'h18, 32'h0000_0010, "R12");

        // clear everything
        wr(6'h00, 32'hFFFF_FFFF);
        chk_rd(6'h1C, 32'h0, "R11");
        chk_irq(2'b00, "R7");

        @(negedge clk);
        wait (q_exp.size() == 0);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule